// File: doc/BRIEF.md
# Audio Coprocessor Interval Timers

This block gives an 8-bit audio coprocessor three programmable interval timers. The coprocessor runs from a 1.024 MHz clock, which reaches the block as a clock enable on the system clock. Each timer has a fixed prescaler. Timers 0 and 1 produce a base tick once every 128 enabled cycles, which is 8 kHz. Timer 2 produces a base tick once every 16 enabled cycles, which is 64 kHz.

Each timer counts its base ticks in a stage counter. When the stage counter reaches the timer's 8-bit period, it wraps to zero and a 4-bit output counter advances. Software polls the output counter, and a poll clears it. An external bus decoder drives the block through a small register window. Offsets 0 to 2 hold the period registers. Offsets 3 to 5 hold the output counters of timers 0, 1 and 2.

Top module: `audio_interval_timers`

## Requirements
- R1: While a timer is enabled, its base tick comes once every 128 cycles with `cpu_clk_en` high for timers 0 and 1. For timer 2 it comes once every 16 such cycles.
- R2: Each period register is 8 bits wide and resets to 0. A period value of 0 means 256 base ticks.
- R3: On a base tick, if the stage count plus one is at least the period, the stage count wraps to 0 and the 4-bit output counter increments modulo 16. Otherwise the stage count increments.
- R4: A read at offset 3+n (n = 0..2) shows timer n's output counter on `rd_data` in the same cycle, and the counter becomes 0 at the next edge. If an increment falls in that same cycle, the counter becomes 1 instead, so no tick is lost.
- R5: A write at offset 3+n clears timer n's output counter in the same way as a read. The write data has no effect.
- R6: When `tmr_en[n]` goes from 0 to 1, timer n's stage count, output counter and prescaler phase all restart from zero. The first base tick then comes a full prescaler interval after that edge.
- R7: While `tmr_en[n]` is 0, timer n produces no base ticks and its output counter holds its value. While `cpu_clk_en` is 0, no timer advances.
- R8: A write at offset n (n = 0..2) loads timer n's period only if the data differs from the stored value. The write never resets the stage count or the prescaler, so a stage count already at or above a new, smaller period wraps on the next tick.
- R9: After reset, all output counters read 0.
- R10: When `acc_rd` is 1 and the offset is 0, 1, 2, 6 or 7, `rd_data` reads 0 and no counter changes. A write to offset 6 or 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_clk_en | input | 1 | One-cycle pulse at the coprocessor clock rate |
| tmr_en | input | 3 | Per-timer enable, bit n enables timer n |
| acc_addr | input | 3 | Register offset within the timer window |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 4 | Output counter of the addressed timer during a read, otherwise 0 |

## Verification
Two cases are hard to reach from the ports. The first is a poll that lands in the exact cycle an output counter increments. The second is a period write that drops below a stage count already reached. The slow timers take hundreds of cycles per increment, so the stimulus uses small periods and a long run of random reads, writes, period changes and enable toggles, with `cpu_clk_en` gated at random. Together these make coincident clears and increments, and stage counts above a shrunk period, occur many times. Directed segments cover the period-of-zero interval, the enable restart, and the holding of a disabled timer.

// File: rtl/audio_tmr_pkg.sv
package audio_tmr_pkg;

    localparam int NUM_TIMERS = 3;
    localparam int PER_W      = 8;
    localparam int OUT_W      = 4;
    localparam int ADDR_W     = 3;

    typedef logic [PER_W-1:0] period_t;
    typedef logic [PER_W:0]   period_eff_t;
    typedef logic [OUT_W-1:0] outcnt_t;

    typedef struct packed {
        period_t stage;
        outcnt_t outcnt;
    } tmr_state_t;

    // Zero in the period register selects the full 2**PER_W ticks.
    function automatic period_eff_t eff_period(input period_t p);
        return (p == '0) ? period_eff_t'(1 << PER_W) : {1'b0, p};
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase;

    assign tick = run && (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
        end else if (run) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    // R1: ticks are never back to back when the divider exceeds one
    p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && DIV > 1) |=> !tick);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import audio_tmr_pkg::*;
#(
    parameter int DIV = 128
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clk_en,
    input  logic    en,
    input  logic    per_we,
    input  period_t per_wdata,
    input  logic    cnt_clr,
    output outcnt_t out_cnt
);
    tmr_state_t st, st_nxt;
    period_t    period_q;
    logic       en_q;
    logic       rise;
    logic       tick;
    logic       inc;

    assign rise = en && !en_q;

    tmr_prescaler #(.DIV(DIV)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (rise),
        .run     (en && clk_en && !rise),
        .tick    (tick)
    );

    always_comb begin
        st_nxt = st;
        inc    = 1'b0;
        if (tick) begin
            if (period_eff_t'(st.stage) + 1'b1 >= eff_period(period_q)) begin
                st_nxt.stage = '0;
                inc          = 1'b1;
            end else begin
                st_nxt.stage = st.stage + 1'b1;
            end
        end
        if (cnt_clr) begin
            st_nxt.outcnt = outcnt_t'(inc);
        end else begin
            st_nxt.outcnt = st.outcnt + outcnt_t'(inc);
        end
        if (rise) begin
            st_nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            period_q <= '0;
            en_q     <= 1'b0;
        end else begin
            st   <= st_nxt;
            en_q <= en;
            if (per_we && (per_wdata != period_q)) begin
                period_q <= per_wdata;
            end
        end
    end

    assign out_cnt = st.outcnt;

    // R6: an enable edge leaves the output counter at zero
    p_enable_clears_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |=> (out_cnt == '0));

    // R7: a disabled, uncleared timer keeps its output counter
    p_hold_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        (!en && !cnt_clr) |=> (out_cnt == $past(out_cnt)));

    // R4: a clear with no tick leaves zero
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_clr && !tick && !rise) |=> (out_cnt == '0));

    // R3: without a tick and without a clear the counter does not move
    p_no_tick_no_move_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_clr && !rise) |=> $stable(out_cnt));

endmodule

// File: rtl/audio_interval_timers.sv
module audio_interval_timers
    import audio_tmr_pkg::*;
#(
    parameter int SLOW_DIV = 128,
    parameter int FAST_DIV = 16,
    parameter int FAST_IDX = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_clk_en,
    input  logic [NUM_TIMERS-1:0] tmr_en,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic                  acc_rd,
    input  logic                  acc_wr,
    input  logic [PER_W-1:0]      acc_wdata,
    output logic [OUT_W-1:0]      rd_data
);
    localparam logic [ADDR_W-1:0] CNT_BASE = ADDR_W'(NUM_TIMERS);

    outcnt_t               cnt   [NUM_TIMERS];
    logic [NUM_TIMERS-1:0] per_we;
    logic [NUM_TIMERS-1:0] cnt_clr;

    always_comb begin
        per_we  = '0;
        cnt_clr = '0;
        rd_data = '0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (acc_wr && acc_addr == ADDR_W'(i)) begin
                per_we[i] = 1'b1;
            end
            if ((acc_rd || acc_wr) && acc_addr == CNT_BASE + ADDR_W'(i)) begin
                cnt_clr[i] = 1'b1;
            end
            if (acc_rd && acc_addr == CNT_BASE + ADDR_W'(i)) begin
                rd_data = cnt[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        localparam int DIV = (g == FAST_IDX) ? FAST_DIV : SLOW_DIV;
        tmr_channel #(.DIV(DIV)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .clk_en    (cpu_clk_en),
            .en        (tmr_en[g]),
            .per_we    (per_we[g]),
            .per_wdata (acc_wdata),
            .cnt_clr   (cnt_clr[g]),
            .out_cnt   (cnt[g])
        );
    end

    // R10: at most one counter is cleared per access
    p_single_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cnt_clr));

    // R10: no read strobe, no read data
    p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !acc_rd |-> (rd_data == '0));

endmodule

// File: tb/audio_interval_timers_bench.sv
module audio_interval_timers_bench;
    localparam int N  = 3;
    localparam int SD = 128;
    localparam int FD = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_clk_en = 1'b0;
    logic [2:0] tmr_en = '0;
    logic [2:0] acc_addr = '0;
    logic       acc_rd = 1'b0;
    logic       acc_wr = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [3:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    audio_interval_timers u_audio_interval_timers (
        .clk(clk), .rst(rst), .cpu_clk_en(cpu_clk_en), .tmr_en(tmr_en),
        .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_wdata(acc_wdata), .rd_data(rd_data)
    );

    // Expected state, derived from the requirements
    int m_presc [N];
    int m_stage [N];
    int m_out   [N];
    int m_per   [N];
    bit m_enq   [N];

    function automatic int div_of(int i);
        return (i == 2) ? FD : SD;
    endfunction

    function automatic int eff(int p);
        return (p == 0) ? 256 : p;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                m_presc[i] = 0; m_stage[i] = 0; m_out[i] = 0;
                m_per[i] = 0; m_enq[i] = 0;
            end else begin
                bit inc;
                bit clr;
                inc = 0;
                clr = (acc_rd || acc_wr) && (acc_addr == 3'(3 + i));
                if (tmr_en[i] && !m_enq[i]) begin
                    m_presc[i] = 0; m_stage[i] = 0; m_out[i] = 0;
                end else begin
                    if (tmr_en[i] && cpu_clk_en) begin
                        if (m_presc[i] == div_of(i) - 1) begin
                            m_presc[i] = 0;
                            if (m_stage[i] + 1 >= eff(m_per[i])) begin
                                m_stage[i] = 0; inc = 1;
                            end else begin
                                m_stage[i] = m_stage[i] + 1;
                            end
                        end else begin
                            m_presc[i] = m_presc[i] + 1;
                        end
                    end
                    m_out[i] = clr ? int'(inc) : ((m_out[i] + int'(inc)) & 15);
                end
                if (acc_wr && acc_addr == 3'(i)) m_per[i] = int'(acc_wdata);
                m_enq[i] = tmr_en[i];
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // One access cycle; reads are checked against the expected counter
    task automatic access(string req, bit rd, bit wr, int addr, int data);
        @(negedge clk);
        acc_addr = 3'(addr); acc_rd = rd; acc_wr = wr; acc_wdata = 8'(data);
        #1;
        if (rd) check(req, int'(rd_data), (addr >= 3 && addr < 6) ? m_out[addr-3] : 0);
        @(negedge clk);
        acc_rd = 0; acc_wr = 0;
    endtask

    // Read without clearing effect is impossible, so peek checks only
    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle(3);
        rst = 0;
        cpu_clk_en = 1;
        // R9: reset state
        for (int i = 0; i < N; i++) access("R9", 1, 0, 3 + i, 0);

        // R2: period 0 means 256 ticks on timer 2
        tmr_en = 3'b100;
        idle(256 * FD + 4);
        access("R2", 1, 0, 5, 0);

        // R1: timer 0 period 1, one increment per 128 cycles
        access("R8", 0, 1, 0, 1);
        tmr_en = 3'b101;
        idle(SD * 3 + 5);
        access("R1", 1, 0, 3, 0);
        idle(SD * 2);
        access("R3", 1, 0, 3, 0);

        // R7: disabled timer holds, clk_en low stalls
        idle(SD * 2);
        tmr_en = 3'b100;
        idle(SD * 4);
        access("R7", 1, 0, 3, 0);
        cpu_clk_en = 0;
        idle(300);
        access("R7", 1, 0, 5, 0);
        cpu_clk_en = 1;

        // R6: re-enable restarts timer 0
        tmr_en = 3'b101;
        idle(SD - 2);
        access("R6", 1, 0, 3, 0);
        idle(SD * 2);
        access("R6", 1, 0, 3, 0);

        // R5: counter write clears, data ignored
        idle(SD * 3);
        access("R5", 0, 1, 3, 8'hFF);
        access("R5", 1, 0, 3, 0);

        // R8: shrink timer 2 period mid-count
        access("R8", 0, 1, 2, 40);
        idle(FD * 30);
        access("R8", 0, 1, 2, 3);
        idle(FD * 4);
        access("R8", 1, 0, 5, 0);
        access("R8", 0, 1, 2, 3);
        idle(FD * 7);
        access("R8", 1, 0, 5, 0);

        // R10: non-counter offsets read 0
        access("R10", 1, 0, 0, 0);
        access("R10", 1, 0, 2, 0);
        access("R10", 1, 0, 6, 0);
        access("R10", 0, 1, 7, 8'h55);
        access("R10", 1, 0, 7, 0);

        // Random mix, R4 coincidences included
        tmr_en = 3'b111;
        access("R8", 0, 1, 1, 2);
        for (int k = 0; k < 9000; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            @(negedge clk);
            cpu_clk_en = ($urandom_range(0, 3) != 0);
            if (r < 6) access("R4", 1, 0, 3 + int'($urandom_range(0, 2)), 0);
            else if (r < 8) access("R5", 0, 1, 3 + int'($urandom_range(0, 2)), int'($urandom));
            else if (r < 10) access("R8", 0, 1, int'($urandom_range(0, 2)), int'($urandom_range(1, 5)));
            else if (r < 11) access("R10", 1, 0, 6 + int'($urandom_range(0, 1)), 0);
            else if (r == 11) tmr_en = 3'($urandom_range(0, 7));
            else if (r == 12) tmr_en = 3'b111;
        end
        for (int i = 0; i < N; i++) access("R3", 1, 0, 3 + i, 0);
        finish_run();
    end

endmodule